// File: doc/BRIEF.md
# Power-Up Reset Timeout Sequencer

This block keeps the core in reset for a configurable number of slow watchdog-oscillator cycles. The count starts once the combined reset request from the external pin, the power-on detector and the brown-out detector has gone away. The count runs on its own free-running slow clock, so it does not depend on the main oscillator having settled. When the count completes, the reset is released into the system clock domain. The release is synchronous to that clock, while assertion takes effect at once.

Static configuration inputs choose the clock source, the timeout length and an optional divide-by-8 prescaler. These inputs are active-low in the way configuration bits are stored, so 0 means programmed. The block decodes the source select into a source kind. A reserved code falls back to the internal RC source and raises an error flag. The block also generates a system clock-enable strobe that either pulses once every eight cycles or stays high. The shipping configuration is select 0010, start-up field 10 and divide bit 0. It gives the RC source, the longest timeout and divide-by-8.

Top module: `rst_timeout_seq`

## Requirements
- R1: `clk_sel_cfg` decodes onto `src_kind` (0 = internal RC, 1 = external clock, 2 = low-power crystal, 3 = full-swing crystal) with `cfg_err` = 0. The codes map as follows: 1000 to 1111 give 2, 0110 and 0111 give 3, 0010 gives 0, and 0000 gives 1.
- R2: The reserved select codes 0001, 0011, 0100 and 0101 give `src_kind` = 0 (internal RC) with `cfg_err` = 1.
- R3: The timeout runs on `wdt_clk`. After `rst_req_raw` falls, `sys_rst` stays high for at least N and at most N+6 `wdt_clk` cycles. N depends on `sut_cfg`: 00 gives 0, 01 gives 512, and 10 or 11 give 8192.
- R4: A high `rst_req_raw` drives `sys_rst` high with no clock edge needed. `sys_rst` falls only on a rising edge of `sys_clk`.
- R5: If `rst_req_raw` is reasserted while the timeout is counting, the count is discarded. After the next release, the full N-cycle timeout runs again.
- R6: With `div8_n_cfg` = 0, `sys_ce` is high for one `sys_clk` cycle out of every 8. With `div8_n_cfg` = 1, `sys_ce` is high on every cycle.
- R7: `sys_ce` is low whenever `sys_rst` is high.
- R8: The shipping configuration (select 0010, start-up 10, divide bit 0) gives the internal RC source, the 8192-cycle timeout and a one-in-eight clock enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wdt_clk | input | 1 | Free-running watchdog-oscillator clock |
| sys_clk | input | 1 | Selected main clock |
| rst_req_raw | input | 1 | Combined reset request from all other sources, active high |
| clk_sel_cfg | input | 4 | Clock-source select configuration field |
| sut_cfg | input | 2 | Start-up timeout length field |
| div8_n_cfg | input | 1 | Divide-by-8 configuration bit, 0 = enabled |
| sys_rst | output | 1 | Internal reset, synchronous to `sys_clk` on release |
| src_kind | output | 2 | Decoded clock source kind |
| cfg_err | output | 1 | Reserved select code seen |
| sys_ce | output | 1 | System clock-enable strobe |

## Verification
Assertions check several properties on every cycle:
- the counter never passes its selected length;
- a synchronised request always clears the completion flag, and completion is sticky while no request is present;
- release reaches the system domain only after completion;
- the enable stays low in reset and never fires two cycles in a row when dividing;
- an error flag always comes with the RC fallback.

The actual timeout lengths in slow-clock cycles, restart after a mid-count glitch, release alignment to the fast clock and the enable density can only be shown by the bench scenarios. Those scenarios measure them across the two independent clocks.

// File: rtl/rtseq_pkg.sv
package rtseq_pkg;

   typedef enum logic [1:0] {
      SRC_RC      = 2'd0,
      SRC_EXT     = 2'd1,
      SRC_XTAL_LP = 2'd2,
      SRC_XTAL_FS = 2'd3
   } src_kind_e;

   typedef struct packed {
      src_kind_e kind;
      logic      bad;
   } src_dec_t;

   // Priority matters: the top bit alone marks the low-power crystal range.
   function automatic src_dec_t decode_sel(input logic [3:0] sel);
      src_dec_t r;
      r.bad = 1'b0;
      casez (sel)
         4'b1???: r.kind = SRC_XTAL_LP;
         4'b011?: r.kind = SRC_XTAL_FS;
         4'b0010: r.kind = SRC_RC;
         4'b0000: r.kind = SRC_EXT;
         default: begin
            r.kind = SRC_RC;
            r.bad  = 1'b1;
         end
      endcase
      return r;
   endfunction

endpackage

// File: rtl/rtseq_sync.sv
module rtseq_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic arst,
   input  logic d,
   output logic q
);
   if (STAGES < 2) begin : g_bad_stages
      $error("rtseq_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0] chain;

   always_ff @(posedge clk or posedge arst) begin
      if (arst) chain <= '1;
      else      chain <= {chain[STAGES-2:0], d};
   end

   assign q = chain[STAGES-1];
endmodule

// File: rtl/rtseq_src_decode.sv
module rtseq_src_decode
   import rtseq_pkg::*;
#(
   parameter int SEL_W = 4
) (
   input  logic [SEL_W-1:0] sel,
   output src_kind_e        kind,
   output logic             bad
);
   if (SEL_W != 4) begin : g_bad_width
      $error("rtseq_src_decode: select field must be 4 bits");
   end

   src_dec_t dec;

   always_comb begin
      dec  = decode_sel(sel);
      kind = dec.kind;
      bad  = dec.bad;
   end
endmodule

// File: rtl/rtseq_timeout.sv
module rtseq_timeout #(
   parameter int SHORT_CYC  = 512,
   parameter int LONG_CYC   = 8192,
   parameter bit ALLOW_ZERO = 1'b1,
   parameter int SYNC_STG   = 2,
   localparam int CNT_W     = $clog2(LONG_CYC + 1)
) (
   input  logic       wdt_clk,
   input  logic       rst_req_raw,
   input  logic [1:0] sut,
   output logic       done
);
   if (SHORT_CYC < 1 || LONG_CYC <= SHORT_CYC) begin : g_bad_len
      $error("rtseq_timeout: need 0 < SHORT_CYC < LONG_CYC");
   end

   logic             req_sync;
   logic [CNT_W-1:0] cnt;
   logic [CNT_W-1:0] target;

   rtseq_sync #(.STAGES(SYNC_STG)) u_req_sync (
      .clk  (wdt_clk),
      .arst (rst_req_raw),
      .d    (1'b0),
      .q    (req_sync)
   );

   if (ALLOW_ZERO) begin : g_zero_ok
      always_comb begin
         case (sut)
            2'b00:   target = '0;
            2'b01:   target = CNT_W'(SHORT_CYC);
            default: target = CNT_W'(LONG_CYC);
         endcase
      end
   end else begin : g_zero_off
      always_comb begin
         if (sut[1]) target = CNT_W'(LONG_CYC);
         else        target = CNT_W'(SHORT_CYC);
      end
   end

   always_ff @(posedge wdt_clk or posedge rst_req_raw) begin
      if (rst_req_raw) begin
         cnt  <= '0;
         done <= 1'b0;
      end else if (req_sync) begin
         cnt  <= '0;
         done <= 1'b0;
      end else if (!done) begin
         if (cnt >= target) done <= 1'b1;
         else               cnt  <= cnt + 1'b1;
      end
   end

   AST_CNT_BOUND: assert property (@(posedge wdt_clk) disable iff (rst_req_raw)
      (!done && $stable(sut)) |-> cnt <= target); // R3
   AST_REQ_CLEARS_DONE: assert property (@(posedge wdt_clk) disable iff (rst_req_raw)
      req_sync |=> !done); // R5
   AST_DONE_STICKY: assert property (@(posedge wdt_clk) disable iff (rst_req_raw)
      (done && !req_sync) |=> done); // R3
endmodule

// File: rtl/rtseq_prescale.sv
module rtseq_prescale #(
   parameter int DIV_RATIO = 8,
   localparam int CW       = (DIV_RATIO > 1) ? $clog2(DIV_RATIO) : 1
) (
   input  logic clk,
   input  logic rst,
   input  logic div_en,
   output logic ce
);
   if (DIV_RATIO < 1 || (DIV_RATIO & (DIV_RATIO - 1)) != 0) begin : g_bad_ratio
      $error("rtseq_prescale: DIV_RATIO must be a power of two");
   end

   if (DIV_RATIO == 1) begin : g_passthru
      always_ff @(posedge clk or posedge rst) begin
         if (rst) ce <= 1'b0;
         else     ce <= 1'b1;
      end
   end else begin : g_divide
      localparam logic [CW-1:0] LAST = CW'(DIV_RATIO - 1);
      logic [CW-1:0] cnt;
      always_ff @(posedge clk or posedge rst) begin
         if (rst) begin
            cnt <= '0;
            ce  <= 1'b0;
         end else begin
            cnt <= cnt + 1'b1;
            ce  <= div_en ? (cnt == LAST) : 1'b1;
         end
      end
      AST_CE_SPACING: assert property (@(posedge clk) disable iff (rst)
         (div_en && $stable(div_en) && ce) |=> !ce); // R6
   end

   AST_CE_QUIET_IN_RESET: assert property (@(posedge clk)
      rst |-> !ce); // R7
endmodule

// File: rtl/rst_timeout_seq.sv
module rst_timeout_seq
   import rtseq_pkg::*;
#(
   parameter int SHORT_CYC  = 512,
   parameter int LONG_CYC   = 8192,
   parameter bit ALLOW_ZERO = 1'b1,
   parameter int SYNC_STG   = 2,
   parameter int DIV_RATIO  = 8
) (
   input  logic       wdt_clk,
   input  logic       sys_clk,
   input  logic       rst_req_raw,
   input  logic [3:0] clk_sel_cfg,
   input  logic [1:0] sut_cfg,
   input  logic       div8_n_cfg,
   output logic       sys_rst,
   output logic [1:0] src_kind,
   output logic       cfg_err,
   output logic       sys_ce
);
   logic      done;
   src_kind_e kind;

   rtseq_src_decode #(.SEL_W(4)) u_dec (
      .sel  (clk_sel_cfg),
      .kind (kind),
      .bad  (cfg_err)
   );
   assign src_kind = kind;

   rtseq_timeout #(
      .SHORT_CYC  (SHORT_CYC),
      .LONG_CYC   (LONG_CYC),
      .ALLOW_ZERO (ALLOW_ZERO),
      .SYNC_STG   (SYNC_STG)
   ) u_tmo (
      .wdt_clk     (wdt_clk),
      .rst_req_raw (rst_req_raw),
      .sut         (sut_cfg),
      .done        (done)
   );

   rtseq_sync #(.STAGES(SYNC_STG)) u_sys_sync (
      .clk  (sys_clk),
      .arst (!done),
      .d    (1'b0),
      .q    (sys_rst)
   );

   rtseq_prescale #(.DIV_RATIO(DIV_RATIO)) u_pre (
      .clk    (sys_clk),
      .rst    (sys_rst),
      .div_en (!div8_n_cfg),
      .ce     (sys_ce)
   );

   AST_RELEASE_AFTER_DONE: assert property (@(posedge sys_clk) disable iff (rst_req_raw)
      $fell(sys_rst) |-> done); // R4
   AST_ERR_FALLBACK: assert property (@(posedge sys_clk) disable iff (sys_rst)
      cfg_err |-> src_kind == 2'd0); // R2
endmodule

// File: tb/tb_rst_timeout_seq.sv
`timescale 1ns/1ps
module tb_rst_timeout_seq;
   logic       wdt_clk = 1'b0;
   logic       sys_clk = 1'b0;
   logic       rst_req_raw = 1'b1;
   logic [3:0] clk_sel_cfg = 4'b0010;
   logic [1:0] sut_cfg = 2'b10;
   logic       div8_n_cfg = 1'b0;
   logic       sys_rst;
   logic [1:0] src_kind;
   logic       cfg_err;
   logic       sys_ce;

   int n_cmp = 0;
   int n_bad = 0;

   always #2 sys_clk = ~sys_clk;
   always #4 wdt_clk = ~wdt_clk;

   rst_timeout_seq dut (
      .wdt_clk(wdt_clk), .sys_clk(sys_clk), .rst_req_raw(rst_req_raw),
      .clk_sel_cfg(clk_sel_cfg), .sut_cfg(sut_cfg), .div8_n_cfg(div8_n_cfg),
      .sys_rst(sys_rst), .src_kind(src_kind), .cfg_err(cfg_err), .sys_ce(sys_ce)
   );

   function automatic int exp_kind(input int sel);
      if (sel >= 8) return 2;
      if (sel == 6 || sel == 7) return 3;
      if (sel == 0) return 1;
      return 0;
   endfunction

   function automatic bit exp_err(input int sel);
      return (sel == 1 || sel == 3 || sel == 4 || sel == 5);
   endfunction

   function automatic int exp_len(input int sut);
      if (sut == 0) return 0;
      if (sut == 1) return 512;
      return 8192;
   endfunction

   task automatic check(input string req, input int act, input int exp);
      n_cmp++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic check_range(input string req, input int act, input int lo, input int hi);
      n_cmp++;
      if (act < lo || act > hi) begin
         n_bad++;
         $display("FAIL %s: actual %0d expected %0d..%0d", req, act, lo, hi);
      end
   endtask

   task automatic check_decode(input int sel);
      clk_sel_cfg = 4'(sel);
      #1;
      check("R1/R2 kind", int'(src_kind), exp_kind(sel));
      check("R1/R2 err", int'(cfg_err), int'(exp_err(sel)));
   endtask

   // Hold reset, check quiet enable, release and measure in wdt cycles.
   task automatic release_and_measure(input int sut, output int cyc);
      int n;
      n = 0;
      @(negedge wdt_clk);
      rst_req_raw = 1'b0;
      while (sys_rst && n < 9000) begin
         @(negedge wdt_clk);
         n++;
      end
      cyc = n;
      check_range("R3 timeout", n, exp_len(sut), exp_len(sut) + 6);
   endtask

   task automatic hold_reset(input int sut, input bit div_n);
      int hi;
      @(negedge wdt_clk);
      rst_req_raw = 1'b1;
      #1;
      check("R4 async assert", int'(sys_rst), 1);
      sut_cfg = 2'(sut);
      div8_n_cfg = div_n;
      hi = 0;
      for (int i = 0; i < 16; i++) begin
         @(negedge sys_clk);
         hi += int'(sys_ce);
      end
      check("R7 ce in reset", hi, 0);
   endtask

   task automatic check_ce(input bit div_n);
      int hi;
      int run;
      int maxrun;
      hi = 0; run = 0; maxrun = 0;
      repeat (12) @(negedge sys_clk);
      for (int i = 0; i < 64; i++) begin
         @(negedge sys_clk);
         hi += int'(sys_ce);
         run = sys_ce ? run + 1 : 0;
         if (run > maxrun) maxrun = run;
      end
      check("R6 ce density", hi, div_n ? 64 : 8);
      check("R6 ce run", maxrun, div_n ? 64 : 1);
   endtask

   task automatic finish_run();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   endtask

   // Release edge of sys_rst must line up with a sys_clk rising edge (at 2 mod 4 ns).
   always @(negedge sys_rst) begin
      if ($time > 0) check("R4 sync release", int'($time % 4), 2);
   end

   initial begin
      repeat (190000) @(posedge sys_clk);
      n_bad++;
      $display("FAIL watchdog: actual hung expected done");
      finish_run();
   end

   initial begin
      int cyc;
      void'($urandom(32'h5eed_0417));
      repeat (4) @(negedge sys_clk);
      check("R4 reset state", int'(sys_rst), 1);
      check("R7 reset state ce", int'(sys_ce), 0);

      // R1 R2: every select code, then random ones.
      for (int s = 0; s < 16; s++) check_decode(s);
      for (int k = 0; k < 8; k++) check_decode(int'($urandom % 16));

      // R8: shipping configuration.
      clk_sel_cfg = 4'b0010;
      hold_reset(2, 1'b0);
      #1;
      check("R8 kind", int'(src_kind), 0);
      check("R8 err", int'(cfg_err), 0);
      release_and_measure(2, cyc);
      check_ce(1'b0);

      // R3 zero length, R6 no divide.
      hold_reset(0, 1'b1);
      release_and_measure(0, cyc);
      check_ce(1'b1);

      // R5: glitch mid-count restarts the short timeout.
      hold_reset(1, 1'b0);
      @(negedge wdt_clk);
      rst_req_raw = 1'b0;
      repeat (300) @(negedge wdt_clk);
      check("R5 still held mid-count", int'(sys_rst), 1);
      rst_req_raw = 1'b1;
      #1;
      check("R5 glitch asserts", int'(sys_rst), 1);
      repeat (2) @(negedge wdt_clk);
      release_and_measure(1, cyc);
      check_ce(1'b0);

      // Constrained random configurations.
      for (int k = 0; k < 4; k++) begin
         int s;
         int sel;
         bit d;
         s = int'($urandom % 4);
         d = 1'($urandom % 2);
         sel = int'($urandom % 16);
         hold_reset(s, d);
         check_decode(sel);
         release_and_measure(s, cyc);
         check_ce(d);
      end

      finish_run();
   end
endmodule